// File: doc/BRIEF.md
# NACK-Fair Rotating Bus Arbiter

This block decides which of several processors may place its request into a shared request buffer in the current cycle. While the buffer signals that it is full, no grant is issued, and every processor that is requesting receives a refusal (NACK) for that cycle. The refused processors retry later.

Retries alone could starve a processor. Each time the buffer fills, the others could win the slots that free up. To prevent this, the arbiter keeps a rotating favourite pointer. The pointer moves on by one each time the buffer goes from not full to full, and it does not move on grants. When room appears, the favourite processor has top priority. The other processors follow in ring order after it. A processor that keeps its request raised therefore sees at most as many refused fill episodes as there are processors before it is served.

Grant and NACK are combinational functions of the current request lines, the full flag and the registered pointer. The only state is the pointer and a one-cycle copy of the full flag, which is used to find fill events.

Top module: `nack_fair_arb`

## Requirements
- R1: After reset the favourite pointer is processor 0. With the buffer free and every processor requesting, the grant is bit 0.
- R2: In any cycle with `buf_full` high, `grant` is all zero.
- R3: `nack[i]` is high exactly when `req[i]` and `buf_full` are both high. With the buffer free, no NACK is driven.
- R4: `grant` has at most one bit set, and only on a processor whose `req` bit is high.
- R5: The pointer moves on by one at each clock edge where `buf_full` is high and was low at the previous edge. A full flag held high for many cycles moves it only once. With the buffer free, the pointer holds.
- R6: The pointer wraps from processor N_REQ-1 to processor 0. After k fill events from reset, with all processors requesting and the buffer free, the grant is bit k mod N_REQ.
- R7: With the buffer free, a requesting favourite processor is always the one granted.
- R8: If the favourite processor is not requesting, the grant goes to the first requester found searching upward from the favourite index and wrapping past N_REQ-1 to 0.
- R9: With the buffer free and at least one request raised, some grant is issued.
- R10: A processor that holds its request raised is refused in at most N_REQ fill episodes between two grants.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_REQ | Per-processor request lines, bit i for processor i |
| buf_full | input | 1 | High while the shared request buffer has no room |
| grant | output | N_REQ | One-hot (or zero) grant, same cycle as the request |
| nack | output | N_REQ | Per-processor refusal, same cycle as the request |

## Verification
Grant and NACK follow the inputs in the same cycle. The bench therefore drives inputs on the falling edge and compares outputs one nanosecond later, before the next rising edge. A fill event changes the pointer at the rising edge where it is seen, so its effect on priority appears from the next driven cycle. The bench model updates its own pointer only after that edge. The starvation bound is checked by counting refused fill episodes per processor while all requests stay raised, and clearing a count whenever that processor is granted.

// File: rtl/nfa_pkg.sv
// Shared helpers for the NACK-fair arbiter: ring arithmetic on processor indices.
package nfa_pkg;

    // Advance an index by one on a ring of size span.
    function automatic int ring_step(input int cur, input int span);
        return (cur + 1 >= span) ? 0 : cur + 1;
    endfunction

    // Index reached by moving off places up from base on a ring of size span.
    function automatic int ring_add(input int base, input int off, input int span);
        return (base + off) % span;
    endfunction

endpackage

// File: rtl/nfa_fill_ptr.sv
// Favourite pointer for the NACK-fair arbiter.
// It keeps a registered copy of the full flag and advances the pointer once on each
// rising edge of that flag (a fill event). It assumes N_REQ >= 2 and uses a
// synchronous active-low reset. A full flag already high when reset releases counts
// as a fill event.
module nfa_fill_ptr #(
    parameter int N_REQ = 4,
    parameter int PW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          buf_full,
    output logic [PW-1:0] ptr
);
    import nfa_pkg::*;

    logic full_q;
    logic fill_evt;

    // Detect the transition from room available to full.
    always_comb fill_evt = buf_full & ~full_q;

    // Hold the previous full flag and rotate the pointer on each fill event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            ptr    <= '0;
        end else begin
            full_q <= buf_full;
            if (fill_evt) begin
                ptr <= PW'(ring_step(int'(ptr), N_REQ));
            end
        end
    end

endmodule

// File: rtl/nfa_rr_pick.sv
// Round-robin selector. It grants the first raised request found searching upward
// from index ptr and wrapping around. With en low it grants nothing. The block is
// purely combinational, and ptr must be below N_REQ.
module nfa_rr_pick #(
    parameter int N_REQ = 4,
    parameter int PW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             en,
    input  logic [N_REQ-1:0] req,
    input  logic [PW-1:0]    ptr,
    output logic [N_REQ-1:0] grant
);
    import nfa_pkg::*;

    logic          found;
    logic [PW-1:0] idx;

    // Scan the ring from the favourite index and take the first requester.
    always_comb begin
        grant = '0;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N_REQ; k++) begin
            idx = PW'(ring_add(int'(ptr), k, N_REQ));
            if (en && !found && req[idx]) begin
                grant[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/nack_fair_arb.sv
// NACK-fair rotating bus arbiter (top).
// While the shared buffer is full, it refuses every raised request and grants none.
// While there is room, it grants one requester, favouring the processor named by a
// pointer that rotates on each fill event. The grant and NACK are combinational,
// and the reset is synchronous active-low.
module nack_fair_arb #(
    parameter int N_REQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    input  logic             buf_full,
    output logic [N_REQ-1:0] grant,
    output logic [N_REQ-1:0] nack
);
    localparam int PW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    logic [PW-1:0] next_ptr;
    logic          room;

    // Grants are only possible while the buffer has room.
    always_comb room = ~buf_full;

    nfa_fill_ptr #(.N_REQ(N_REQ), .PW(PW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_full (buf_full),
        .ptr      (next_ptr)
    );

    nfa_rr_pick #(.N_REQ(N_REQ), .PW(PW)) u_pick (
        .en    (room),
        .req   (req),
        .ptr   (next_ptr),
        .grant (grant)
    );

    // One refusal line per processor: a raised request meets a full buffer.
    for (genvar g = 0; g < N_REQ; g++) begin : g_nack
        always_comb nack[g] = req[g] & buf_full;
    end

endmodule

// File: rtl/nack_fair_arb_chk.sv
// Assertion checker for nack_fair_arb. It is bound into the top module and watches
// the ports and the favourite pointer.
module nack_fair_arb_chk #(
    parameter int N_REQ = 4,
    parameter int PW    = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req,
    input logic             buf_full,
    input logic [N_REQ-1:0] grant,
    input logic [N_REQ-1:0] nack,
    input logic [PW-1:0]    ptr
);
    import nfa_pkg::*;

    a_r2_full_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> (grant == '0));

    a_r3_no_nack_with_room: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_full |-> (nack == '0));

    a_r3_nack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (nack & ~req) == '0);

    a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    a_r5_step_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_full) |=> (int'(ptr) == ring_step(int'($past(ptr)), N_REQ)));

    a_r5_hold_with_room: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_full |=> $stable(ptr));

    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < N_REQ);

    a_r7_favourite_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_full && req[ptr]) |-> grant[ptr]);

    a_r9_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_full && req != '0) |-> (grant != '0));

endmodule

bind nack_fair_arb nack_fair_arb_chk #(.N_REQ(N_REQ)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .buf_full (buf_full),
    .grant    (grant),
    .nack     (nack),
    .ptr      (next_ptr)
);

// File: tb/nack_fair_arb_tb.sv
`timescale 1ns/1ps
module nack_fair_arb_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         buf_full = 1'b0;
    logic [N-1:0] grant;
    logic [N-1:0] nack;

    int checks = 0;
    int failures = 0;
    int mptr = 0;
    logic mprev = 1'b0;
    int ep_cnt [N];

    nack_fair_arb #(.N_REQ(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .buf_full(buf_full),
        .grant(grant), .nack(nack)
    );

    always #2.5 clk = ~clk;

    // Expected grant from the requirements: nothing while full, else ring search from ptr.
    function automatic logic [N-1:0] exp_grant(input logic [N-1:0] r, input logic f, input int p);
        logic [N-1:0] g = '0;
        if (!f) begin
            for (int k = 0; k < N; k++) begin
                if (g == '0 && r[(p + k) % N]) g[(p + k) % N] = 1'b1;
            end
        end
        return g;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check 1 ns later, then update the model at the rising edge.
    task automatic step(input logic [N-1:0] r, input logic f);
        @(negedge clk);
        req = r;
        buf_full = f;
        #1;
        chk("R2/R4/R7/R8/R9 grant", grant, exp_grant(r, f, mptr));
        chk("R3 nack", nack, f ? r : '0);
        @(posedge clk);
        if (f && !mprev) mptr = (mptr + 1) % N;
        mprev = f;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        buf_full = 1'b0;
        repeat (3) @(posedge clk);
        mptr = 0;
        mprev = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();

        // R1: the pointer starts at processor 0.
        @(negedge clk);
        req = '1;
        #1;
        chk("R1 reset favourite", grant, 4'b0001);
        chk("R1 reset nack", nack, 4'b0000);

        // R6: after k fill events the favourite is processor k mod N, including the wrap.
        for (int k = 1; k <= N + 1; k++) begin
            step('1, 1'b1);
            step('1, 1'b0);
            @(negedge clk);
            req = '1;
            buf_full = 1'b0;
            #1;
            chk("R6 rotation/wrap", grant, 4'(1 << (k % N)));
        end

        // R5: a long full period moves the pointer only once.
        do_reset();
        repeat (6) step(4'b1111, 1'b1);
        @(negedge clk);
        req = '1;
        buf_full = 1'b0;
        #1;
        chk("R5 single advance", grant, 4'b0010);

        // R5: cycles with room leave the pointer unchanged.
        repeat (5) step(4'b0000, 1'b0);
        @(negedge clk);
        req = '1;
        #1;
        chk("R5 hold with room", grant, 4'b0010);

        // R8: favourite 1 is idle, so the search from 1 passes 2 and finds 3 before 0.
        @(negedge clk);
        req = 4'b1001;
        #1;
        chk("R8 ring order", grant, 4'b1000);

        // R7: the favourite wins over lower-index requesters.
        @(negedge clk);
        req = 4'b0011;
        #1;
        chk("R7 favourite first", grant, 4'b0010);

        // R2/R3: a full buffer refuses every requester.
        @(negedge clk);
        req = 4'b1011;
        buf_full = 1'b1;
        #1;
        chk("R2 no grant when full", grant, 4'b0000);
        chk("R3 nack all requesters", nack, 4'b1011);
        @(posedge clk);
        if (!mprev) mptr = (mptr + 1) % N;
        mprev = 1'b1;

        // Random mix checked against the model (R2, R3, R4, R7, R8, R9).
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            step(4'($urandom_range(0, 15)), ($urandom_range(0, 99) < 35));
        end

        // R10: all requests stay raised; count refused fill episodes per processor.
        do_reset();
        for (int j = 0; j < N; j++) ep_cnt[j] = 0;
        for (int i = 0; i < 3000; i++) begin
            logic f;
            f = ($urandom_range(0, 99) < 50);
            @(negedge clk);
            req = '1;
            buf_full = f;
            #1;
            chk("R4/R7 grant under load", grant, exp_grant('1, f, mptr));
            for (int j = 0; j < N; j++) begin
                if (grant[j]) ep_cnt[j] = 0;
                if (f && !mprev && nack[j]) begin
                    ep_cnt[j]++;
                    checks++;
                    if (ep_cnt[j] > N) begin
                        failures++;
                        $display("FAIL R10 proc %0d refused episodes actual=%0d expected<=%0d",
                                 j, ep_cnt[j], N);
                    end
                end
            end
            @(posedge clk);
            if (f && !mprev) mptr = (mptr + 1) % N;
            mprev = f;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule